// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Arbiter

The arbiter keeps the routing and priority state of a set of interrupt sources and decides, separately for each CPU, which of them that CPU should be told about. For every source it holds an enable bit, a pending bit, a group bit and an 8-bit priority. Sources below `PRIV_IRQS` are private, so each CPU has its own copy of their state. Sources at or above `PRIV_IRQS` are shared: they have one copy of their state plus a target mask that lists the CPUs allowed to receive them.

Each CPU slice steps through the sources one per clock and keeps the best eligible candidate. At the end of each full pass it registers three results for that CPU: the highest-pending ID, an IRQ line and an FIQ line. When a CPU decides the winner it compares the winner's priority with two values: a priority mask, which sets whether the winner is reported at all, and a running priority, which sets whether the winner may interrupt the CPU. The CPU's group-enable inputs and its FIQ-enable input then decide which line is raised.

State is changed through a one-cycle write port, and pending bits are cleared through a separate acknowledge strobe. Each CPU's control values are plain inputs. A write or an acknowledge restarts the scan.

Top module: `irq_prio_arbiter`

## Requirements
- R1: Synchronous reset clears every enable, pending, group and target bit. It also drives every IRQ and FIQ output low and sets every highest-pending ID to 1023.
- R2: A CPU's IRQ and FIQ stay low and its highest-pending ID reads 1023 in either of two cases: both global group enables (`glob_grp_en`) are 0, or both of that CPU's group enables are 0.
- R3: A source is eligible for a CPU when it is enabled and pending in that CPU's view. A shared source (ID >= 32) must also have that CPU's bit set in its target mask. A private source (ID < 32) needs no target bit.
- R4: Among eligible sources, the one with the numerically lowest priority wins. If two sources have equal priority, the lower ID wins.
- R5: The winner's ID is reported only if its priority is strictly below the CPU's priority mask. Otherwise the report is 1023.
- R6: A reported winner raises a line only when two conditions hold. Its priority must be strictly below the CPU's 9-bit running priority (0x100 means idle). Its group must be enabled both globally and for that CPU. Bit 0 of each group-enable pair controls group 0, and bit 1 controls group 1.
- R7: A group-0 winner raises FIQ if the CPU's FIQ enable is 1, and raises IRQ otherwise. A group-1 winner always raises IRQ. IRQ and FIQ of one CPU are never high together.
- R8: The acknowledge strobe clears the pending bit of `ack_id`. For a private ID it clears only `ack_cpu`'s copy, and for a shared ID it clears every CPU's copy. When a write and an acknowledge hit the same pending bit in the same cycle, the acknowledge wins.
- R9: Write field codes on `wr_field`: 0 sets enable, 1 sets pending, 2 sets group (all three from `wr_data[0]`), 3 sets priority (from `wr_data[7:0]`), and 4 sets the target mask (CPU c takes `wr_data[c]`). A write to a private ID changes only `wr_cpu`'s copy. A write to a shared ID changes the state all CPUs see. A target write to a private ID has no effect on eligibility.
- R10: Outputs are registered and change only at the end of a full scan. After a write or acknowledge applied at clock edge E0, the updated result appears at edge E0+NUM_IRQ+1 and not earlier. A change on a control input is reflected within 2*NUM_IRQ+2 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle state write strobe |
| wr_cpu | input | CPU_W | CPU whose private copy a private-ID write targets |
| wr_field | input | 3 | Field code (R9) |
| wr_id | input | ID_W | Source ID written |
| wr_data | input | PRIO_W | Write data |
| ack_en | input | 1 | Acknowledge / clear-pending strobe |
| ack_cpu | input | CPU_W | Acknowledging CPU |
| ack_id | input | ID_W | Source ID acknowledged |
| glob_grp_en | input | 2 | Global enables, bit g for group g |
| cpu_grp_en | input | 2*NUM_CPU | Per-CPU group enables, pair c at [2c+1:2c] |
| cpu_fiq_en | input | NUM_CPU | Per-CPU FIQ enable for group 0 |
| cpu_pmask | input | NUM_CPU*PRIO_W | Per-CPU priority mask |
| cpu_run_prio | input | NUM_CPU*(PRIO_W+1) | Per-CPU running priority, 0x100 when idle |
| irq_o | output | NUM_CPU | Per-CPU IRQ line |
| fiq_o | output | NUM_CPU | Per-CPU FIQ line |
| hp_id_o | output | NUM_CPU*10 | Per-CPU highest-pending ID, 1023 for none |

## Verification
A state write or acknowledge reaches the outputs exactly NUM_IRQ+1 edges after the edge on which it is applied. One directed check samples the outputs on the falling edge just before that edge, expecting the old value, and on the falling edge just after it, expecting the new one. Control inputs are sampled only at the end of a scan. Every other check therefore waits 2*NUM_IRQ+4 edges after its last stimulus, which covers one partial scan and one full scan, before comparing against the bench's model.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int HP_W = 10;
  localparam logic [HP_W-1:0] NO_IRQ_ID = 10'd1023;

  typedef enum logic [2:0] {
    FLD_ENABLE  = 3'd0,
    FLD_PENDING = 3'd1,
    FLD_GROUP   = 3'd2,
    FLD_PRIO    = 3'd3,
    FLD_TARGET  = 3'd4
  } fld_e;
endpackage

// File: rtl/irq_arb_bank.sv
// Per-CPU view of source state: bit flops plus a priority RAM with synchronous read.
module irq_arb_bank
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int PRIV_IRQS = 32,
  parameter int PRIO_W    = 8,
  parameter int ID_W      = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  fld_e              wr_field,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [PRIO_W-1:0] wr_data,
  input  logic              wr_tgt,
  input  logic              ack_hit,
  input  logic [ID_W-1:0]   ack_id,
  input  logic [ID_W-1:0]   rd_idx,
  output logic              rd_elig,
  output logic              rd_grp,
  output logic [PRIO_W-1:0] rd_prio
);
  logic [NUM_IRQ-1:0] en_q, pend_q, grp_q, tgt_q;
  logic [PRIO_W-1:0]  prio_mem [NUM_IRQ];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pend_q <= '0;
      grp_q  <= '0;
      tgt_q  <= '0;
    end else begin
      if (wr_hit) begin
        case (wr_field)
          FLD_ENABLE:  en_q[wr_id]   <= wr_data[0];
          FLD_PENDING: pend_q[wr_id] <= wr_data[0];
          FLD_GROUP:   grp_q[wr_id]  <= wr_data[0];
          FLD_TARGET:  tgt_q[wr_id]  <= wr_tgt;
          default: ;
        endcase
      end
      // acknowledge is applied last so it wins over a same-cycle pending write
      if (ack_hit) pend_q[ack_id] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_hit && wr_field == FLD_PRIO) prio_mem[wr_id] <= wr_data;
    rd_prio <= prio_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_elig <= 1'b0;
      rd_grp  <= 1'b0;
    end else begin
      rd_elig <= en_q[rd_idx] & pend_q[rd_idx] &
                 ((int'(rd_idx) < PRIV_IRQS) | tgt_q[rd_idx]);
      rd_grp  <= grp_q[rd_idx];
    end
  end

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
    ack_hit |=> !pend_q[$past(ack_id)]);

  assert_enable_write_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && wr_field == FLD_ENABLE) |=> en_q[$past(wr_id)] == $past(wr_data[0]));
endmodule

// File: rtl/irq_arb_scan.sv
// Sequential best-candidate search for one CPU, with end-of-scan decision registers.
module irq_arb_scan
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8,
  parameter int ID_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  output logic [ID_W-1:0]   rd_idx,
  input  logic              cand_elig,
  input  logic              cand_grp,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic [1:0]        glob_en,
  input  logic [1:0]        cpu_en,
  input  logic              fiq_en,
  input  logic [PRIO_W-1:0] pmask,
  input  logic [PRIO_W:0]   run_prio,
  output logic              irq_o,
  output logic              fiq_o,
  output logic [HP_W-1:0]   hp_o
);
  localparam logic [ID_W-1:0] LAST_ID = ID_W'(NUM_IRQ - 1);

  logic [ID_W-1:0]   idx_q, s1_id;
  logic              s1_valid;
  logic              best_found;
  logic [PRIO_W-1:0] best_prio;
  logic [ID_W-1:0]   best_id;
  logic              best_grp;

  logic              take, last;
  logic              nxt_found, nxt_grp;
  logic [PRIO_W-1:0] nxt_prio;
  logic [ID_W-1:0]   nxt_id;
  logic              off, show, sig, dec_fiq, dec_irq;
  logic [HP_W-1:0]   dec_hp;

  assign rd_idx = idx_q;
  assign last   = s1_valid && (s1_id == LAST_ID);

  always_comb begin
    // strict compare keeps the lower ID on equal priority
    take      = s1_valid && cand_elig && (!best_found || cand_prio < best_prio);
    nxt_found = take ? 1'b1      : best_found;
    nxt_prio  = take ? cand_prio : best_prio;
    nxt_id    = take ? s1_id     : best_id;
    nxt_grp   = take ? cand_grp  : best_grp;

    off     = (glob_en == 2'b00) || (cpu_en == 2'b00);
    show    = nxt_found && !off && (nxt_prio < pmask);
    sig     = show && ({1'b0, nxt_prio} < run_prio) && glob_en[nxt_grp] && cpu_en[nxt_grp];
    dec_fiq = sig && !nxt_grp && fiq_en;
    dec_irq = sig && !dec_fiq;
    dec_hp  = show ? HP_W'(nxt_id) : NO_IRQ_ID;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q      <= '0;
      s1_id      <= '0;
      s1_valid   <= 1'b0;
      best_found <= 1'b0;
      best_prio  <= '0;
      best_id    <= '0;
      best_grp   <= 1'b0;
      irq_o      <= 1'b0;
      fiq_o      <= 1'b0;
      hp_o       <= NO_IRQ_ID;
    end else if (restart) begin
      idx_q      <= '0;
      s1_valid   <= 1'b0;
      best_found <= 1'b0;
    end else begin
      idx_q    <= (idx_q == LAST_ID) ? '0 : idx_q + 1'b1;
      s1_valid <= 1'b1;
      s1_id    <= idx_q;
      if (last) begin
        best_found <= 1'b0;
        irq_o      <= dec_irq;
        fiq_o      <= dec_fiq;
        hp_o       <= dec_hp;
      end else begin
        best_found <= nxt_found;
        best_prio  <= nxt_prio;
        best_id    <= nxt_id;
        best_grp   <= nxt_grp;
      end
    end
  end

  assert_one_line_R7: assert property (@(posedge clk) disable iff (rst)
    !(irq_o && fiq_o));

  assert_fiq_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(fiq_o) |-> $past(fiq_en));

  assert_line_has_id_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_o || fiq_o) |-> hp_o != NO_IRQ_ID);

  assert_hold_between_scans_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(last) |-> $stable({irq_o, fiq_o, hp_o}));
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int NUM_CPU   = 2,
  parameter int PRIV_IRQS = 32,
  parameter int PRIO_W    = 8,
  parameter int ID_W      = $clog2(NUM_IRQ),
  parameter int CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [CPU_W-1:0]            wr_cpu,
  input  logic [2:0]                  wr_field,
  input  logic [ID_W-1:0]             wr_id,
  input  logic [PRIO_W-1:0]           wr_data,
  input  logic                        ack_en,
  input  logic [CPU_W-1:0]            ack_cpu,
  input  logic [ID_W-1:0]             ack_id,
  input  logic [1:0]                  glob_grp_en,
  input  logic [2*NUM_CPU-1:0]        cpu_grp_en,
  input  logic [NUM_CPU-1:0]          cpu_fiq_en,
  input  logic [NUM_CPU*PRIO_W-1:0]   cpu_pmask,
  input  logic [NUM_CPU*(PRIO_W+1)-1:0] cpu_run_prio,
  output logic [NUM_CPU-1:0]          irq_o,
  output logic [NUM_CPU-1:0]          fiq_o,
  output logic [NUM_CPU*HP_W-1:0]     hp_id_o
);
  localparam int RP_W = PRIO_W + 1;

  logic restart, wr_shared, ack_shared;
  fld_e fld;

  assign restart    = wr_en | ack_en;
  assign wr_shared  = int'(wr_id) >= PRIV_IRQS;
  assign ack_shared = int'(ack_id) >= PRIV_IRQS;
  assign fld        = fld_e'(wr_field);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic              wr_hit, ack_hit;
    logic [ID_W-1:0]   rd_idx;
    logic              rd_elig, rd_grp;
    logic [PRIO_W-1:0] rd_prio;

    assign wr_hit  = wr_en  && (wr_shared  || wr_cpu  == CPU_W'(c));
    assign ack_hit = ack_en && (ack_shared || ack_cpu == CPU_W'(c));

    irq_arb_bank #(
      .NUM_IRQ(NUM_IRQ), .PRIV_IRQS(PRIV_IRQS), .PRIO_W(PRIO_W), .ID_W(ID_W)
    ) u_bank (
      .clk(clk), .rst(rst),
      .wr_hit(wr_hit), .wr_field(fld), .wr_id(wr_id), .wr_data(wr_data),
      .wr_tgt(wr_data[c]),
      .ack_hit(ack_hit), .ack_id(ack_id),
      .rd_idx(rd_idx), .rd_elig(rd_elig), .rd_grp(rd_grp), .rd_prio(rd_prio)
    );

    irq_arb_scan #(
      .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)
    ) u_scan (
      .clk(clk), .rst(rst), .restart(restart),
      .rd_idx(rd_idx), .cand_elig(rd_elig), .cand_grp(rd_grp), .cand_prio(rd_prio),
      .glob_en(glob_grp_en), .cpu_en(cpu_grp_en[2*c +: 2]), .fiq_en(cpu_fiq_en[c]),
      .pmask(cpu_pmask[c*PRIO_W +: PRIO_W]), .run_prio(cpu_run_prio[c*RP_W +: RP_W]),
      .irq_o(irq_o[c]), .fiq_o(fiq_o[c]), .hp_o(hp_id_o[c*HP_W +: HP_W])
    );
  end
endmodule

// File: tb/irq_prio_arbiter_tb.sv
`timescale 1ns/1ps
module irq_prio_arbiter_tb;
  localparam int NI = 64;
  localparam int NC = 2;
  localparam int CW = 1;
  localparam int IW = 6;
  localparam int SETTLE = 2*NI + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, ack_en = 1'b0;
  logic [CW-1:0] wr_cpu = '0, ack_cpu = '0;
  logic [2:0] wr_field = '0;
  logic [IW-1:0] wr_id = '0, ack_id = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] glob = 2'b00;
  logic [2*NC-1:0] cen = '0;
  logic [NC-1:0] fen = '0;
  logic [NC*8-1:0] pm = '0;
  logic [NC*9-1:0] rp = '0;
  logic [NC-1:0] irq_o, fiq_o;
  logic [NC*10-1:0] hp_id_o;

  always #2 clk = ~clk;

  irq_prio_arbiter #(.NUM_IRQ(NI), .NUM_CPU(NC)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cpu(wr_cpu), .wr_field(wr_field),
    .wr_id(wr_id), .wr_data(wr_data), .ack_en(ack_en), .ack_cpu(ack_cpu), .ack_id(ack_id),
    .glob_grp_en(glob), .cpu_grp_en(cen), .cpu_fiq_en(fen), .cpu_pmask(pm),
    .cpu_run_prio(rp), .irq_o(irq_o), .fiq_o(fiq_o), .hp_id_o(hp_id_o)
  );

  bit en_m [NC][NI];
  bit pd_m [NC][NI];
  bit gp_m [NC][NI];
  bit tg_m [NC][NI];
  int pr_m [NC][NI];
  int vectors = 0, errors = 0;
  bit done = 1'b0;
  int unsigned seed = 32'h1234_5678;

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[30:16]);
  endfunction

  task automatic model(input int c, output bit ei, output bit ef, output int eh);
    bit found = 0; int bp = 0; int bi = 0; bit bg = 0; bit off;
    for (int i = 0; i < NI; i++) begin
      if (en_m[c][i] && pd_m[c][i] && (i < 32 || tg_m[c][i]) && (!found || pr_m[c][i] < bp)) begin
        found = 1; bp = pr_m[c][i]; bi = i; bg = gp_m[c][i];
      end
    end
    off = (glob == 2'b00) || (cen[2*c +: 2] == 2'b00);
    ei = 0; ef = 0; eh = 1023;
    if (!off && found && bp < int'(pm[c*8 +: 8])) begin
      eh = bi;
      if (bp < int'(rp[c*9 +: 9]) && glob[bg] && cen[2*c + int'(bg)]) begin
        if (!bg && fen[c]) ef = 1; else ei = 1;
      end
    end
  endtask

  task automatic chk(input string tag);
    bit ei, ef; int eh;
    for (int c = 0; c < NC; c++) begin
      model(c, ei, ef, eh);
      vectors++;
      if (irq_o[c] !== ei || fiq_o[c] !== ef || int'(hp_id_o[c*10 +: 10]) != eh) begin
        errors++;
        $display("FAIL %s cpu%0d: irq=%0b fiq=%0b hp=%0d expected irq=%0b fiq=%0b hp=%0d",
                 tag, c, irq_o[c], fiq_o[c], hp_id_o[c*10 +: 10], ei, ef, eh);
      end
    end
  endtask

  task automatic chk_hp(input int c, input int eh, input string tag);
    vectors++;
    if (int'(hp_id_o[c*10 +: 10]) != eh) begin
      errors++;
      $display("FAIL %s cpu%0d: hp=%0d expected hp=%0d", tag, c, hp_id_o[c*10 +: 10], eh);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(posedge clk);
    @(negedge clk);
  endtask

  // one-cycle write and/or acknowledge; returns at the falling edge after it is applied
  task automatic drive(input bit dw, input int fld, input int cpu, input int id, input int data,
                       input bit da, input int acpu, input int aid);
    @(negedge clk);
    wr_en = dw; wr_field = 3'(fld); wr_cpu = CW'(cpu); wr_id = IW'(id); wr_data = 8'(data);
    ack_en = da; ack_cpu = CW'(acpu); ack_id = IW'(aid);
    if (dw) begin
      for (int c = 0; c < NC; c++) begin
        if (id >= 32 || c == cpu) begin
          case (fld)
            0: en_m[c][id] = data[0];
            1: pd_m[c][id] = data[0];
            2: gp_m[c][id] = data[0];
            3: pr_m[c][id] = data & 8'hFF;
            4: tg_m[c][id] = data[c];
            default: ;
          endcase
        end
      end
    end
    if (da) begin
      for (int c = 0; c < NC; c++)
        if (aid >= 32 || c == acpu) pd_m[c][aid] = 0;
    end
    @(negedge clk);
    wr_en = 1'b0; ack_en = 1'b0;
  endtask

  task automatic wr(input int fld, input int cpu, input int id, input int data);
    drive(1, fld, cpu, id, data, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset");

    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NI; i++)
        if (i < 32 || c == 0) wr(3, c, i, (i*37 + c*11 + 64) & 8'hFF);
    for (int c = 0; c < NC; c++) begin
      pm[c*8 +: 8] = 8'hFF; rp[c*9 +: 9] = 9'h100;
    end

    // R2: group enables off
    wr(0, 0, 40, 1); wr(1, 0, 40, 1); wr(4, 0, 40, 3);
    settle(); chk("R2 global off");
    glob = 2'b11; cen = '0;
    settle(); chk("R2 cpu off");
    cen = '1;
    settle(); chk("R3 shared both targets");
    wr(4, 0, 40, 1);
    settle(); chk("R3 shared target cpu0 only");
    wr(0, 1, 5, 1); wr(1, 1, 5, 1);
    settle(); chk("R3 private cpu1");

    // R4: equal priority, lower id wins; then strictly lower priority wins
    wr(4, 0, 40, 3); wr(3, 0, 40, 8'h30); wr(3, 1, 5, 8'h30);
    settle(); chk("R4 tie");
    wr(3, 0, 40, 8'h2F);
    settle(); chk("R4 lower value");

    // R5: mask boundary
    pm[7:0] = 8'h2F;
    settle(); chk("R5 mask equal");
    pm[7:0] = 8'h30;
    settle(); chk("R5 mask above");
    pm[7:0] = 8'hFF;

    // R6: running priority boundary and group gating
    rp[8:0] = 9'h02F;
    settle(); chk("R6 running equal");
    rp[8:0] = 9'h030;
    settle(); chk("R6 running above");
    rp[8:0] = 9'h100;

    // R7: line selection
    fen = 2'b11;
    settle(); chk("R7 group0 fiq");
    wr(2, 0, 40, 1);
    settle(); chk("R7 group1 irq");
    glob = 2'b01;
    settle(); chk("R6 group1 disabled");
    glob = 2'b11; wr(2, 0, 40, 0); fen = 2'b00;
    settle(); chk("R7 group0 fiq off");

    // R8: acknowledge
    drive(0, 0, 0, 0, 0, 1, 1, 40);
    settle(); chk("R8 shared ack");
    drive(0, 0, 0, 0, 0, 1, 0, 5);
    settle(); chk("R8 private ack other cpu");
    drive(1, 1, 0, 40, 1, 1, 0, 40);
    settle(); chk("R8 ack beats write");

    // R9: private target write ignored, private priority banked
    wr(4, 1, 5, 0);
    settle(); chk("R9 private target ignored");
    wr(3, 0, 5, 8'h01);
    settle(); chk("R9 private prio banked");

    // R10: exact latency of a write
    settle();
    chk_hp(0, 1023, "R10 before");
    @(negedge clk);
    wr_en = 1'b1; wr_field = 3'd1; wr_cpu = '0; wr_id = IW'(40); wr_data = 8'd1;
    pd_m[0][40] = 1; pd_m[1][40] = 1;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (NI) @(posedge clk);
    @(negedge clk);
    chk_hp(0, 1023, "R10 one edge early");
    @(negedge clk);
    chk_hp(0, 40, "R10 due edge");

    // random sweep
    for (int it = 0; it < 300; it++) begin
      int op = rnd() % 6;
      int id = rnd() % NI;
      int cpu = rnd() % NC;
      if (op == 5) drive(0, 0, 0, 0, 0, 1, cpu, id);
      else if (op < 3) wr(op, cpu, id, (rnd() % 4 != 0) ? 1 : 0);
      else wr(op, cpu, id, rnd() & 8'hFF);
      if (it % 8 == 0) begin
        glob = (rnd() % 4 == 0) ? 2'(rnd()) : 2'b11;
        cen  = (rnd() % 4 == 0) ? 4'(rnd()) : 4'hF;
        fen  = 2'(rnd());
        for (int c = 0; c < NC; c++) begin
          pm[c*8 +: 8] = 8'(rnd() | 8'h80);
          rp[c*9 +: 9] = (rnd() % 2 == 0) ? 9'h100 : 9'(rnd() & 8'hFF);
        end
      end
      settle(); chk("R3/R4/R5/R6/R7 sweep");
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule